// File: doc/BRIEF.md
# Packed SIMD Compare and Pick Unit

This unit compares two 32-bit source words lane by lane and turns the outcome into a small vector of per-lane flags. In byte mode each word holds four 8-bit lanes, compared as unsigned numbers. In halfword mode it holds two 16-bit lanes, compared as signed two's-complement numbers. Three predicates are offered: A equal to B, A less than B, and A less than or equal to B. The flag for lane i is bit i of the vector.

The flag vector can go to a 4-bit condition field, to the destination register, or to both. The condition field models control-register bits 27:24, so field bit i is control bit 24+i. A pick operation reads the stored condition bits and builds a result word. Each lane comes from source A when its condition bit is 1 and from source B when it is 0.

Each operation is presented for one cycle with `valid_i` high. Its destination write, its condition update and its illegal flag all appear one clock later.

Top module: `simd_cmp_pick`

## Requirements
- R1: While reset is asserted and right after it, `wr_en_o`, `illegal_o` and `cond_o` are all 0.
- R2: Sub-opcodes 0x00, 0x01 and 0x02 compare the byte lanes, unsigned, with equal, less-than and less-or-equal respectively. They load the 4-bit flag vector into `cond_o` and make no register write.
- R3: Sub-opcodes 0x08, 0x09 and 0x0A compare the two halfword lanes as signed values, with equal, less-than and less-or-equal. They load the 2-bit vector into `cond_o[1:0]`, keep `cond_o[3:2]` unchanged and make no register write.
- R4: Sub-opcodes 0x04, 0x05 and 0x06 perform the byte compares of R2. They write the flag vector, zero-extended to 32 bits, to the destination and leave `cond_o` unchanged.
- R5: Sub-opcodes 0x18, 0x19 and 0x1A perform the byte compares of R2. They write the zero-extended vector to the destination and also replace all four bits of `cond_o` with it.
- R6: Sub-opcode 0x03 (byte pick) writes a word whose byte lane i, at bits 8i+7:8i, is taken from source A when `cond_o[i]` is 1 and from source B otherwise. The condition bits used are the ones held before the operation.
- R7: Sub-opcode 0x0B (halfword pick) writes a word whose halfword lane i, at bits 16i+15:16i, is taken from A when `cond_o[i]` is 1 and from B otherwise, for i = 0 and 1.
- R8: If an operation that writes a register (0x03–0x06, 0x0B, 0x18–0x1A) names destination 0, it does nothing: there is no write and `cond_o` does not change. `wr_idx_o` carries the destination index of each write.
- R9: Any other sub-opcode raises `illegal_o` for one cycle, makes no write and leaves `cond_o` unchanged.
- R10: Results appear on the clock edge that samples `valid_i`. A cycle with `valid_i` low produces no write, no illegal flag and no change in `cond_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| subop_i | input | 5 | Sub-opcode |
| dst_i | input | 5 | Destination register index |
| src_a_i | input | 32 | Source word A |
| src_b_i | input | 32 | Source word B |
| wr_en_o | output | 1 | Destination write enable |
| wr_idx_o | output | 5 | Destination index of the write |
| wr_data_o | output | 32 | Destination write data |
| cond_o | output | 4 | Condition field (control bits 27:24) |
| illegal_o | output | 1 | Unassigned sub-opcode seen |

## Verification
Every one of the 32 sub-opcodes is applied to each operand pair, once with destination 0 and once with a nonzero destination. This separates the register-writing operations from the no-op cases and the illegal codes.

Operand pairs come in three kinds:
- Fully equal words separate the equal predicate from less-than.
- Words that differ only in the top bit of a lane separate signed halfword ordering from unsigned byte ordering.
- Pseudo-random words give mixed lane results, so each flag bit and each pick lane is exercised on its own.

Because the sub-opcode order rotates from one pattern to the next, each pick operation reads condition bits left by a different earlier compare, and the halfword compare meets a varied upper condition field.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;
  typedef enum logic [1:0] {
    P_EQ  = 2'd0,
    P_LT  = 2'd1,
    P_LE  = 2'd2,
    P_RSV = 2'd3
  } pred_e;

  typedef enum logic [2:0] {
    K_CCMP_B,  // byte compare -> condition field
    K_GCMP_B,  // byte compare -> register
    K_DCMP_B,  // byte compare -> both
    K_CMP_H,   // halfword compare -> condition field
    K_PICK_B,
    K_PICK_H,
    K_ILL
  } op_kind_e;
endpackage

// File: rtl/simd_cmp_dec.sv
module simd_cmp_dec
  import simd_cmp_pkg::*;
#(
  parameter int unsigned OP_W = 5
) (
  input  logic [OP_W-1:0] subop_i,
  output op_kind_e        kind_o,
  output pred_e           pred_o
);
  always_comb begin
    pred_o = pred_e'(subop_i[1:0]);
    unique case (subop_i)
      5'h00, 5'h01, 5'h02: kind_o = K_CCMP_B;
      5'h03:               kind_o = K_PICK_B;
      5'h04, 5'h05, 5'h06: kind_o = K_GCMP_B;
      5'h08, 5'h09, 5'h0A: kind_o = K_CMP_H;
      5'h0B:               kind_o = K_PICK_H;
      5'h18, 5'h19, 5'h1A: kind_o = K_DCMP_B;
      default:             kind_o = K_ILL;
    endcase
  end
endmodule

// File: rtl/simd_lane_vec.sv
module simd_lane_vec
  import simd_cmp_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4,
  parameter bit          SIGNED = 1'b0,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  pred_e             pred_i,
  output logic [LANES-1:0]  vec_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l;
    logic eq_l, lt_l;
    assign a_l  = a_i[l*LANE_W +: LANE_W];
    assign b_l  = b_i[l*LANE_W +: LANE_W];
    assign eq_l = (a_l == b_l);
    if (SIGNED) begin : g_s
      assign lt_l = $signed(a_l) < $signed(b_l);
    end else begin : g_u
      assign lt_l = a_l < b_l;
    end
    always_comb begin
      unique case (pred_i)
        P_EQ:    vec_o[l] = eq_l;
        P_LT:    vec_o[l] = lt_l;
        default: vec_o[l] = lt_l | eq_l;
      endcase
    end
  end
endmodule

// File: rtl/simd_pick.sv
module simd_pick #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [LANES-1:0]  sel_i,
  output logic [DATA_W-1:0] res_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign res_o[l*LANE_W +: LANE_W] = sel_i[l] ? a_i[l*LANE_W +: LANE_W]
                                                : b_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/simd_cmp_pick.sv
module simd_cmp_pick
  import simd_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned OP_W   = 5,
  localparam int unsigned B_LANES = DATA_W / 8,
  localparam int unsigned H_LANES = DATA_W / 16,
  localparam int unsigned COND_W  = B_LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   subop_i,
  input  logic [IDX_W-1:0]  dst_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [COND_W-1:0] cond_o,
  output logic              illegal_o
);
  op_kind_e kind;
  pred_e    pred;
  logic [B_LANES-1:0] vec_b;
  logic [H_LANES-1:0] vec_h;
  logic [DATA_W-1:0]  pick_b, pick_h;

  logic [COND_W-1:0] cond_q, cond_n;
  logic              wr_n, ill_n, dst_ok;
  logic [DATA_W-1:0] data_n;

  simd_cmp_dec #(.OP_W(OP_W)) u_dec (
    .subop_i(subop_i), .kind_o(kind), .pred_o(pred)
  );

  simd_lane_vec #(.LANE_W(8), .LANES(B_LANES), .SIGNED(1'b0)) u_vec_b (
    .a_i(src_a_i), .b_i(src_b_i), .pred_i(pred), .vec_o(vec_b)
  );

  simd_lane_vec #(.LANE_W(16), .LANES(H_LANES), .SIGNED(1'b1)) u_vec_h (
    .a_i(src_a_i), .b_i(src_b_i), .pred_i(pred), .vec_o(vec_h)
  );

  simd_pick #(.LANE_W(8), .LANES(B_LANES)) u_pick_b (
    .a_i(src_a_i), .b_i(src_b_i), .sel_i(cond_q), .res_o(pick_b)
  );

  simd_pick #(.LANE_W(16), .LANES(H_LANES)) u_pick_h (
    .a_i(src_a_i), .b_i(src_b_i), .sel_i(cond_q[H_LANES-1:0]), .res_o(pick_h)
  );

  assign dst_ok = (dst_i != '0);

  always_comb begin
    cond_n = cond_q;
    wr_n   = 1'b0;
    ill_n  = 1'b0;
    data_n = '0;
    if (valid_i) begin
      unique case (kind)
        K_CCMP_B: cond_n = vec_b;
        K_CMP_H:  cond_n[H_LANES-1:0] = vec_h;
        K_GCMP_B: begin
          wr_n   = dst_ok;
          data_n = DATA_W'(vec_b);
        end
        K_DCMP_B: begin
          // destination 0 squashes the condition update as well
          wr_n   = dst_ok;
          data_n = DATA_W'(vec_b);
          if (dst_ok) cond_n = vec_b;
        end
        K_PICK_B: begin
          wr_n   = dst_ok;
          data_n = pick_b;
        end
        K_PICK_H: begin
          wr_n   = dst_ok;
          data_n = pick_h;
        end
        default: ill_n = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      illegal_o <= 1'b0;
    end else begin
      cond_q    <= cond_n;
      wr_en_o   <= wr_n;
      wr_idx_o  <= dst_i;
      wr_data_o <= wr_n ? data_n : '0;
      illegal_o <= ill_n;
    end
  end

  assign cond_o = cond_q;
endmodule

// File: rtl/simd_cmp_pick_chk.sv
module simd_cmp_pick_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned OP_W   = 5,
  parameter int unsigned COND_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   subop_i,
  input logic [IDX_W-1:0]  dst_i,
  input logic              wr_en_o,
  input logic [IDX_W-1:0]  wr_idx_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic [COND_W-1:0] cond_o,
  input logic              illegal_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!wr_en_o && !illegal_o)); // R10
  AST_IDLE_COND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cond_o)); // R10
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wr_en_o); // R9
  AST_ILLEGAL_COND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (subop_i == 5'h07 || subop_i == 5'h1F) |=> $stable(cond_o) && illegal_o); // R9
  AST_ZERO_DST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dst_i == '0 |=> !wr_en_o); // R8
  AST_WRITE_IDX_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_idx_o != '0); // R8
  AST_REG_CMP_COND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && subop_i inside {5'h04, 5'h05, 5'h06} |=> $stable(cond_o)); // R4
  AST_REG_CMP_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && subop_i inside {5'h04, 5'h05, 5'h06, 5'h18, 5'h19, 5'h1A} |=>
      wr_data_o[DATA_W-1:COND_W] == '0); // R4
  AST_HALF_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && subop_i inside {5'h08, 5'h09, 5'h0A} |=>
      cond_o[COND_W-1:2] == $past(cond_o[COND_W-1:2])); // R3
  AST_COND_ONLY_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && subop_i inside {5'h00, 5'h01, 5'h02, 5'h08, 5'h09, 5'h0A} |=> !wr_en_o); // R2
endmodule

bind simd_cmp_pick simd_cmp_pick_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .OP_W(OP_W), .COND_W(COND_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .subop_i(subop_i),
  .dst_i(dst_i), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
  .wr_data_o(wr_data_o), .cond_o(cond_o), .illegal_o(illegal_o)
);

// File: tb/simd_cmp_pick_tb_top.sv
module simd_cmp_pick_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  subop_i = '0;
  logic [4:0]  dst_i = '0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic        wr_en_o;
  logic [4:0]  wr_idx_o;
  logic [31:0] wr_data_o;
  logic [3:0]  cond_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] cond_m = '0;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk_i = ~clk_i;

  simd_cmp_pick dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .subop_i(subop_i),
    .dst_i(dst_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
    .cond_o(cond_o), .illegal_o(illegal_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (subop %h dst %0d a %h b %h)",
               req, what, act, exp, subop_i, dst_i, src_a_i, src_b_i);
    end
  endtask

  function automatic logic [3:0] byte_vec(logic [31:0] a, logic [31:0] b, int p);
    logic [3:0] v;
    for (int l = 0; l < 4; l++) begin
      int unsigned x = int'(a[8*l +: 8]);
      int unsigned y = int'(b[8*l +: 8]);
      v[l] = (p == 0) ? (x == y) : (p == 1) ? (x < y) : (x <= y);
    end
    return v;
  endfunction

  function automatic logic [1:0] half_vec(logic [31:0] a, logic [31:0] b, int p);
    logic [1:0] v;
    for (int l = 0; l < 2; l++) begin
      int x = int'($signed(a[16*l +: 16]));
      int y = int'($signed(b[16*l +: 16]));
      v[l] = (p == 0) ? (x == y) : (p == 1) ? (x < y) : (x <= y);
    end
    return v;
  endfunction

  function automatic logic [31:0] pick_w(logic [31:0] a, logic [31:0] b,
                                         logic [3:0] c, int lw);
    logic [31:0] r = '0;
    for (int l = 0; l < 32 / lw; l++)
      for (int k = 0; k < lw; k++)
        r[l*lw + k] = c[l] ? a[l*lw + k] : b[l*lw + k];
    return r;
  endfunction

  task automatic run_op(logic [4:0] op, logic [4:0] dst, logic [31:0] a, logic [31:0] b);
    logic        e_wr = 1'b0;
    logic        e_ill = 1'b0;
    logic [31:0] e_dat = '0;
    logic [3:0]  e_cond = cond_m;
    logic        ok = (dst != 0);
    string       req;
    int          p = int'(op[1:0]);
    case (op)
      5'h00, 5'h01, 5'h02: begin req = "R2"; e_cond = byte_vec(a, b, p); end
      5'h03: begin req = "R6"; e_wr = ok; e_dat = pick_w(a, b, cond_m, 8); end
      5'h04, 5'h05, 5'h06: begin req = "R4"; e_wr = ok; e_dat = {28'd0, byte_vec(a, b, p)}; end
      5'h08, 5'h09, 5'h0A: begin req = "R3"; e_cond[1:0] = half_vec(a, b, p); end
      5'h0B: begin req = "R7"; e_wr = ok; e_dat = pick_w(a, b, cond_m, 16); end
      5'h18, 5'h19, 5'h1A: begin
        req = "R5"; e_wr = ok; e_dat = {28'd0, byte_vec(a, b, p)};
        if (ok) e_cond = byte_vec(a, b, p);
      end
      default: begin req = "R9"; e_ill = 1'b1; end
    endcase
    if (!ok && !e_ill && e_wr == 1'b0 && !(op inside {5'h00,5'h01,5'h02,5'h08,5'h09,5'h0A}))
      req = {req, "/R8"};
    if (!e_wr) e_dat = '0;
    subop_i = op; dst_i = dst; src_a_i = a; src_b_i = b; valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, "wr_en", 32'(wr_en_o), 32'(e_wr));
    if (e_wr) begin
      check(req, "wr_data", wr_data_o, e_dat);
      check("R8", "wr_idx", 32'(wr_idx_o), 32'(dst));
    end
    check(req, "illegal", 32'(illegal_o), 32'(e_ill));
    check(req, "cond", 32'(cond_o), 32'(e_cond));
    cond_m = e_cond;
    valid_i = 1'b0;
    subop_i = ~op;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R10", "idle wr_en", 32'(wr_en_o), 32'd0);
    check("R10", "idle illegal", 32'(illegal_o), 32'd0);
    check("R10", "idle cond", 32'(cond_o), 32'(cond_m));
  endtask

  function automatic logic [31:0] next_rng(logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    #2;
    check("R1", "reset wr_en", 32'(wr_en_o), 32'd0);
    check("R1", "reset illegal", 32'(illegal_o), 32'd0);
    check("R1", "reset cond", 32'(cond_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "post-reset cond", 32'(cond_o), 32'd0);
    check("R1", "post-reset wr_en", 32'(wr_en_o), 32'd0);
    for (int k = 0; k < 160; k++) begin
      logic [31:0] a, b;
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng); b = rng;
      case (k % 4)
        0: b = a;                        // all lanes equal
        1: b = a ^ 32'h8000_8000;        // halfword sign flips
        2: b = a ^ 32'h0080_8000;        // byte top-bit flips
        default: ;
      endcase
      for (int s = 0; s < 32; s++) begin
        logic [4:0] op = 5'((s + k) % 32);
        run_op(op, 5'd0, a, b);
        run_op(op, 5'((k % 31) + 1), a, b);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule